// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether an access to a port in a 65536-entry I/O address space may go ahead. A request carries the protection-enable bit, the current privilege level, the I/O privilege level, the virtual-8086 flag, a 16-bit port number and an access size of one, two or four ports. When protection is off, the result is always "allow". When the current level is privileged enough and virtual-8086 mode is off, the result is also always "allow". In every other case the block reads a permission bitmap that holds one bit per port. It denies the access if any bit covering the ports touched by the access is set.

The bitmap sits in an attached memory with a synchronous read of one cycle. Each memory word holds `WORD_W` consecutive port bits. Port `p` is bit `p % WORD_W` of word `p / WORD_W`, and the lowest port sits in the least significant bit. A multi-port access can straddle two words. In that case the block reads both words before it decides. An access that runs past the last port is denied, because the ports beyond the end count as forbidden. Each decision comes out as a one-cycle `res_valid` pulse with complementary allow and fault flags. A fault stands for a general-protection fault with error code 0, which the surrounding logic raises.

Top module: `io_perm_check`

## Requirements
- R1: A request accepted with protection enabled, and with either CPL numerically above IOPL or the virtual-8086 flag set, drives `bm_rd_en` high in its acceptance cycle with `bm_rd_addr` equal to `port / WORD_W`.
- R2: A request accepted with protection off, or with CPL at or below IOPL and the virtual-8086 flag clear, issues no bitmap read and yields `res_valid` with `res_allow`=1 in the next cycle.
- R3: With the virtual-8086 flag set, the bitmap is read even when CPL is at or below IOPL.
- R4: A byte access (`size`=2'b00) is denied exactly when the bit of its own port is 1.
- R5: A word access (`size`=2'b01) checks ports p and p+1. A doubleword access (`size`=2'b10, and 2'b11 treated the same way) checks ports p to p+3. Any set bit among them denies the access.
- R6: An access whose ports cross into the next bitmap word reads that word as well, using a second read. The result then comes 3 cycles after acceptance, compared with 2 cycles for a checked access within one word.
- R7: A checked access that reaches past port 65535 is denied without a second read, and its result comes 2 cycles after acceptance.
- R8: Whenever `res_valid` is 1, `res_fault` is the inverse of `res_allow`.
- R9: During and straight after reset, `req_ready`=1, `res_valid`=0 and `bm_rd_en`=0.
- R10: While a checked access is in progress, `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; request accepted this cycle |
| prot_en | input | 1 | Protection enabled |
| cpl | input | PL_W | Current privilege level |
| iopl | input | PL_W | I/O privilege level |
| v86 | input | 1 | Virtual-8086 mode flag |
| port | input | PORT_W | First port of the access |
| size | input | 2 | 00 byte, 01 word, 10/11 doubleword |
| bm_rd_en | output | 1 | Bitmap read strobe |
| bm_rd_addr | output | PORT_W-log2(WORD_W) | Bitmap word index |
| bm_rd_data | input | WORD_W | Bitmap word, valid one cycle after the strobe |
| res_valid | output | 1 | Decision strobe |
| res_allow | output | 1 | Access permitted |
| res_fault | output | 1 | Access refused (general-protection fault, code 0) |

## Verification
The hardest cases to reach are those where a word or doubleword starts in the last few bit positions of a bitmap word. Only there does the second read happen, and at the very top of the port range the second read must be suppressed in favour of an outright denial. The stimulus table places forbidden ports just across word boundaries, for example a single set bit at the first port of a word. It then starts accesses one to three ports below that boundary, so a wrong mask or a skipped second read changes the verdict. Accesses starting at 0xFFFE and 0xFFFF test the end of the range with an all-clear bitmap there, so only the overflow rule can deny them.

// File: rtl/io_perm_pkg.sv
package io_perm_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'b00,
      SZ_WORD  = 2'b01,
      SZ_DWORD = 2'b10,
      SZ_WIDE  = 2'b11
   } acc_size_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'b00,
      ST_FIRST  = 2'b01,
      ST_SECOND = 2'b10
   } chk_state_e;

   function automatic logic [2:0] span_len(acc_size_e s);
      case (s)
         SZ_BYTE: return 3'd1;
         SZ_WORD: return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/io_perm_gate.sv
module io_perm_gate #(
   parameter int PL_W = 2
) (
   input  logic            prot_en,
   input  logic [PL_W-1:0] cpl,
   input  logic [PL_W-1:0] iopl,
   input  logic            v86,
   output logic            need_check
);
   logic under_priv;

   assign under_priv = (cpl > iopl);
   assign need_check = prot_en & (under_priv | v86);
endmodule

// File: rtl/io_perm_span.sv
module io_perm_span
   import io_perm_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int OFF_W  = $clog2(WORD_W)
) (
   input  logic [OFF_W-1:0]  offset,
   input  acc_size_e         size,
   output logic [WORD_W-1:0] mask_lo,
   output logic [WORD_W-1:0] mask_hi,
   output logic              spills
);
   localparam int SUM_W = OFF_W + 1;

   logic [SUM_W-1:0] start_pos;
   logic [SUM_W-1:0] end_pos;

   assign start_pos = {1'b0, offset};
   assign end_pos   = start_pos + SUM_W'(span_len(size));
   assign spills    = (end_pos > SUM_W'(WORD_W));

   for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      localparam logic [SUM_W-1:0] LO_IDX = SUM_W'(i);
      localparam logic [SUM_W-1:0] HI_IDX = SUM_W'(i + WORD_W);
      assign mask_lo[i] = (LO_IDX >= start_pos) && (LO_IDX < end_pos);
      assign mask_hi[i] = (HI_IDX < end_pos);
   end
endmodule

// File: rtl/io_perm_check.sv
module io_perm_check
   import io_perm_pkg::*;
#(
   parameter int PORT_W = 16,
   parameter int WORD_W = 32,
   parameter int PL_W   = 2,
   localparam int OFF_W  = $clog2(WORD_W),
   localparam int WIDX_W = PORT_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              prot_en,
   input  logic [PL_W-1:0]   cpl,
   input  logic [PL_W-1:0]   iopl,
   input  logic              v86,
   input  logic [PORT_W-1:0] port,
   input  logic [1:0]        size,
   output logic              bm_rd_en,
   output logic [WIDX_W-1:0] bm_rd_addr,
   input  logic [WORD_W-1:0] bm_rd_data,
   output logic              res_valid,
   output logic              res_allow,
   output logic              res_fault
);
   if (WORD_W < 4 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word
      $error("WORD_W must be a power of two of at least 4");
   end
   if (PORT_W <= OFF_W) begin : g_bad_port
      $error("PORT_W must exceed log2(WORD_W)");
   end

   chk_state_e        state_q;
   logic [WIDX_W-1:0] widx_q;
   logic [OFF_W-1:0]  off_q;
   acc_size_e         size_q;
   logic              hit_q;

   logic              need_check;
   logic              fire;
   logic [WORD_W-1:0] mask_lo;
   logic [WORD_W-1:0] mask_hi;
   logic              spills;
   logic              at_top;
   logic              hit_lo;
   logic              hit_hi;
   logic              second_rd;

   io_perm_gate #(.PL_W(PL_W)) i_gate (
      .prot_en    (prot_en),
      .cpl        (cpl),
      .iopl       (iopl),
      .v86        (v86),
      .need_check (need_check)
   );

   io_perm_span #(.WORD_W(WORD_W), .OFF_W(OFF_W)) i_span (
      .offset  (off_q),
      .size    (size_q),
      .mask_lo (mask_lo),
      .mask_hi (mask_hi),
      .spills  (spills)
   );

   assign req_ready = (state_q == ST_IDLE);
   assign fire      = req_valid & req_ready;
   assign at_top    = (widx_q == '1);
   assign hit_lo    = |(bm_rd_data & mask_lo);
   assign hit_hi    = |(bm_rd_data & mask_hi);
   assign second_rd = (state_q == ST_FIRST) & spills & ~at_top;

   assign bm_rd_en   = (fire & need_check) | second_rd;
   assign bm_rd_addr = (state_q == ST_IDLE) ? port[PORT_W-1:OFF_W] : widx_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         widx_q    <= '0;
         off_q     <= '0;
         size_q    <= SZ_BYTE;
         hit_q     <= 1'b0;
         res_valid <= 1'b0;
         res_allow <= 1'b0;
         res_fault <= 1'b0;
      end else begin
         res_valid <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (fire) begin
                  widx_q <= port[PORT_W-1:OFF_W];
                  off_q  <= port[OFF_W-1:0];
                  size_q <= acc_size_e'(size);
                  if (need_check) begin
                     state_q <= ST_FIRST;
                  end else begin
                     res_valid <= 1'b1;
                     res_allow <= 1'b1;
                     res_fault <= 1'b0;
                  end
               end
            end
            ST_FIRST: begin
               if (second_rd) begin
                  hit_q   <= hit_lo;
                  state_q <= ST_SECOND;
               end else begin
                  res_valid <= 1'b1;
                  res_allow <= ~(hit_lo | spills);
                  res_fault <= hit_lo | spills;
                  state_q   <= ST_IDLE;
               end
            end
            ST_SECOND: begin
               res_valid <= 1'b1;
               res_allow <= ~(hit_q | hit_hi);
               res_fault <= hit_q | hit_hi;
               state_q   <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/io_perm_check_sva.sv
module io_perm_check_sva #(
   parameter int PORT_W = 16,
   parameter int WORD_W = 32,
   parameter int PL_W   = 2,
   localparam int OFF_W  = $clog2(WORD_W),
   localparam int WIDX_W = PORT_W - OFF_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              prot_en,
   input logic [PL_W-1:0]   cpl,
   input logic [PL_W-1:0]   iopl,
   input logic              v86,
   input logic [PORT_W-1:0] port,
   input logic              bm_rd_en,
   input logic [WIDX_W-1:0] bm_rd_addr,
   input logic              res_valid,
   input logic              res_allow,
   input logic              res_fault
);
   logic accepted;
   logic checked;

   assign accepted = req_valid & req_ready;
   assign checked  = prot_en & ((cpl > iopl) | v86);

   assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_allow != res_fault));

   assert_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (accepted && !checked) |=> (res_valid && res_allow));

   assert_noread_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (accepted && !checked) |-> !bm_rd_en);

   assert_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (accepted && checked) |-> (bm_rd_en && bm_rd_addr == port[PORT_W-1:OFF_W]));

   assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (accepted && checked) |=> (!req_ready && !res_valid));
endmodule

bind io_perm_check io_perm_check_sva #(
   .PORT_W (PORT_W),
   .WORD_W (WORD_W),
   .PL_W   (PL_W)
) i_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .prot_en    (prot_en),
   .cpl        (cpl),
   .iopl       (iopl),
   .v86        (v86),
   .port       (port),
   .bm_rd_en   (bm_rd_en),
   .bm_rd_addr (bm_rd_addr),
   .res_valid  (res_valid),
   .res_allow  (res_allow),
   .res_fault  (res_fault)
);

// File: tb/test_io_perm_check.sv
module test_io_perm_check;
   localparam int PORT_W = 16;
   localparam int WORD_W = 32;
   localparam int PL_W   = 2;
   localparam int WIDX_W = PORT_W - 5;
   localparam int NWORDS = 1 << WIDX_W;
   localparam int NVEC   = 22;

   // fields: prot, cpl, iopl, v86, port, size, expected fault, latency
   localparam logic [26:0] VEC [NVEC] = '{
      {1'b0, 2'd3, 2'd0, 1'b0, 16'h0060, 2'd0, 1'b0, 2'd1}, // R2 real mode
      {1'b1, 2'd0, 2'd0, 1'b0, 16'h0060, 2'd0, 1'b0, 2'd1}, // R2 cpl == iopl
      {1'b1, 2'd3, 2'd0, 1'b0, 16'h0060, 2'd0, 1'b1, 2'd2}, // R4 set bit
      {1'b1, 2'd3, 2'd0, 1'b0, 16'h0061, 2'd0, 1'b0, 2'd2}, // R4 clear bit
      {1'b1, 2'd0, 2'd3, 1'b1, 16'h0060, 2'd0, 1'b1, 2'd2}, // R3 v86 deny
      {1'b1, 2'd0, 2'd3, 1'b1, 16'h0061, 2'd0, 1'b0, 2'd2}, // R3 v86 allow
      {1'b1, 2'd3, 2'd0, 1'b0, 16'h0400, 2'd2, 1'b1, 2'd2}, // R5 dword top port set
      {1'b1, 2'd3, 2'd0, 1'b0, 16'h0401, 2'd1, 1'b0, 2'd2}, // R5 word clear
      {1'b1, 2'd3, 2'd0, 1'b0, 16'h0402, 2'd1, 1'b1, 2'd2}, // R5 word second port set
      {1'b1, 2'd3, 2'd0, 1'b0, 16'h005F, 2'd1, 1'b1, 2'd3}, // R6 word spill hit
      {1'b1, 2'd3, 2'd0, 1'b0, 16'h043E, 2'd2, 1'b1, 2'd3}, // R6 dword spill hit
      {1'b1, 2'd2, 2'd1, 1'b0, 16'h043D, 2'd2, 1'b1, 2'd3}, // R6 dword spill last port
      {1'b1, 2'd2, 2'd1, 1'b0, 16'h043C, 2'd2, 1'b0, 2'd2}, // R5 ends on word edge
      {1'b1, 2'd3, 2'd0, 1'b0, 16'h0438, 2'd2, 1'b0, 2'd2}, // R5 dword clear
      {1'b1, 2'd3, 2'd0, 1'b0, 16'hFFFE, 2'd1, 1'b0, 2'd2}, // R7 fits at top
      {1'b1, 2'd3, 2'd0, 1'b0, 16'hFFFE, 2'd2, 1'b1, 2'd2}, // R7 dword past top
      {1'b1, 2'd3, 2'd0, 1'b0, 16'hFFFF, 2'd1, 1'b1, 2'd2}, // R7 word past top
      {1'b1, 2'd3, 2'd0, 1'b0, 16'hFFFF, 2'd0, 1'b0, 2'd2}, // R7 last byte
      {1'b1, 2'd1, 2'd2, 1'b0, 16'h1000, 2'd0, 1'b0, 2'd1}, // R2 cpl below iopl
      {1'b1, 2'd2, 2'd1, 1'b0, 16'h1000, 2'd0, 1'b1, 2'd2}, // R4 cpl above iopl
      {1'b1, 2'd3, 2'd0, 1'b0, 16'h041F, 2'd2, 1'b0, 2'd3}, // R6 spill all clear
      {1'b1, 2'd3, 2'd0, 1'b0, 16'h0400, 2'd3, 1'b1, 2'd2}  // R5 size 11 as dword
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              prot_en = 1'b0;
   logic [PL_W-1:0]   cpl = '0;
   logic [PL_W-1:0]   iopl = '0;
   logic              v86 = 1'b0;
   logic [PORT_W-1:0] port = '0;
   logic [1:0]        size = '0;
   logic              bm_rd_en;
   logic [WIDX_W-1:0] bm_rd_addr;
   logic [WORD_W-1:0] bm_rd_data = '0;
   logic              res_valid;
   logic              res_allow;
   logic              res_fault;

   logic [WORD_W-1:0] bm [NWORDS];
   int                rd_total = 0;
   int                n_total = 0;
   int                n_fail = 0;

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (bm_rd_en) begin
         bm_rd_data <= bm[bm_rd_addr];
         rd_total   <= rd_total + 1;
      end
   end

   io_perm_check #(.PORT_W(PORT_W), .WORD_W(WORD_W), .PL_W(PL_W)) i_io_perm_check (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .prot_en    (prot_en),
      .cpl        (cpl),
      .iopl       (iopl),
      .v86        (v86),
      .port       (port),
      .size       (size),
      .bm_rd_en   (bm_rd_en),
      .bm_rd_addr (bm_rd_addr),
      .bm_rd_data (bm_rd_data),
      .res_valid  (res_valid),
      .res_allow  (res_allow),
      .res_fault  (res_fault)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic void deny_port(input int p);
      bm[p / WORD_W][p % WORD_W] = 1'b1;
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      for (int i = 0; i < NWORDS; i++) bm[i] = '0;
      deny_port(16'h0060);
      deny_port(16'h0403);
      deny_port(16'h0440);
      deny_port(16'h1000);

      repeat (3) @(negedge clk);
      check(req_ready == 1'b1, "R9 ready in reset", int'(req_ready), 1);
      check(res_valid == 1'b0, "R9 valid in reset", int'(res_valid), 0);
      check(bm_rd_en == 1'b0, "R9 read in reset", int'(bm_rd_en), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1 && res_valid == 1'b0, "R9 after reset",
            int'({req_ready, res_valid}), 2);

      for (int v = 0; v < NVEC; v++) begin
         logic [26:0] e;
         int          lat;
         int          exp_lat;
         int          rd_start;
         e = VEC[v];
         exp_lat = int'(e[1:0]);
         @(negedge clk);
         prot_en   = e[26];
         cpl       = e[25:24];
         iopl      = e[23:22];
         v86       = e[21];
         port      = e[20:5];
         size      = e[4:3];
         req_valid = 1'b1;
         #2;
         check(bm_rd_en == (exp_lat > 1), "R1/R2 read strobe at accept",
               int'(bm_rd_en), int'(exp_lat > 1));
         if (exp_lat > 1)
            check(bm_rd_addr == e[20:10], "R1 read address", int'(bm_rd_addr), int'(e[20:10]));
         rd_start = rd_total;
         @(negedge clk);
         req_valid = 1'b0;
         if (exp_lat > 1)
            check(req_ready == 1'b0, "R10 busy while checking", int'(req_ready), 0);
         lat = 1;
         while (!res_valid && lat < 6) begin
            @(negedge clk);
            lat++;
         end
         check(lat == exp_lat, $sformatf("R6/R7 latency vec %0d", v), lat, exp_lat);
         check(res_fault == e[2], $sformatf("R4/R5 fault vec %0d", v), int'(res_fault), int'(e[2]));
         check(res_allow == !e[2], $sformatf("R8 allow vec %0d", v), int'(res_allow), int'(!e[2]));
         check(rd_total - rd_start == exp_lat - 1, $sformatf("R6/R7 reads vec %0d", v),
               rd_total - rd_start, exp_lat - 1);
         @(negedge clk);
         check(res_valid == 1'b0, "R8 single-cycle result", int'(res_valid), 0);
      end

      // reset in the middle of a spilling check returns to idle
      @(negedge clk);
      prot_en = 1'b1; cpl = 2'd3; iopl = 2'd0; v86 = 1'b0;
      port = 16'h005F; size = 2'd1; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check(req_ready == 1'b1 && res_valid == 1'b0 && bm_rd_en == 1'b0, "R9 mid-check reset",
            int'({req_ready, res_valid, bm_rd_en}), 4);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(res_valid == 1'b0, "R9 no stale result", int'(res_valid), 0);

      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end
endmodule